// File: doc/BRIEF.md
# System Configuration Register Bank

This block holds a small set of 32-bit configuration words behind a simple word-wide bus that decodes a 1 KiB window. Every word has its own write rule. Some keep only a masked subset of the written bits. Some only accumulate set bits, which clear again only on reset. One flag is cleared by writing a one to it. One bit can be cleared by software but is set again only by reset. The bits themselves drive nothing inside the block; other logic consumes them.

The block also steers external interrupt lines. Each attached port supplies 16 pin levels. For every output line `p`, a 4-bit selector field names the port whose pin `p` drives that line. A selector that names a port which is not attached holds its line low.

A bus access is one cycle with `bus_valid` high. Read data and the error flag come back registered on the following cycle. A hardware event input raises the parity flag in configuration word 2.

Top module: `sys_cfg_bank`

## Requirements
- R1: After reset, the word at 0x04 reads 0x7C000001 and every other mapped word reads 0.
- R2: A write to 0x00 keeps only the bits in mask 0x00000107. A write to 0x24 keeps only bits 7:0. A write to any selector word (0x08, 0x0C, 0x10, 0x14) keeps only bits 15:0.
- R3: At 0x04, the bits in mask 0xFCFF0100 take the written value. Bit 0 is cleared by writing 0 and is never set by a write; only reset sets it.
- R4: At 0x1C, bits 3:0 are set by writing 1 and stay set until reset. Writing 0 to them leaves them unchanged.
- R5: At 0x1C, bit 8 is set by a `parity_evt` pulse and cleared by writing 1 to bit 8. Writing 0 to bit 8 leaves it unchanged. If an event and a clearing write fall in the same cycle, the bit ends up set.
- R6: The words at 0x20 and 0x28 OR each written value into their contents. Their bits clear only on reset.
- R7: Writes to 0x18 are ignored, and that word always reads 0.
- R8: An access to an unmapped offset (above 0x28) or to an address with bits 1:0 nonzero raises `bus_err` on the next cycle. Such a read returns 0, and such a write changes no word.
- R9: Read data for an access in cycle n appears on `bus_rdata` in cycle n+1.
- R10: Line `p` equals pin `p` of port `s`. Here `s` is the 4-bit field at bits (p%4)*4+3:(p%4)*4 of the selector word at 0x08+4*(p/4), and port `s` occupies `port_pins[s*16+15:s*16]`.
- R11: When a line's selector field holds a value of `NUM_PORTS` or more, that line is low whatever the pin levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Unmapped or misaligned access, registered |
| parity_evt | input | 1 | Hardware event that sets the parity flag |
| port_pins | input | NUM_PORTS*16 | Pin levels, port k in bits k*16+15:k*16 |
| irq_lines | output | 16 | Steered interrupt lines |

## Verification
The bench builds the block with `NUM_PORTS` set to 5. With that value a selector can name an attached port (0 to 4), and it can also name an absent port (5 to 15), so the forced-low path on a line is driven directly from the bus. The narrower pin bus also lets the bench set each attached port to a pattern of its own, so a line steered to the wrong port shows a wrong level.

// File: rtl/sys_cfg_bank.sv
module sys_cfg_bank #(
  parameter int NUM_PORTS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [9:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_err,
  input  logic                    parity_evt,
  input  logic [NUM_PORTS*16-1:0] port_pins,
  output logic [15:0]             irq_lines
);
  localparam logic [31:0] REMAP_MASK = 32'h0000_0107;
  localparam logic [31:0] CFG1_MASK  = 32'hFCFF_0100;
  localparam logic [31:0] CFG1_RST   = 32'h7C00_0001;
  localparam logic [7:0]  LAST_WORD  = 8'd10;
  localparam logic [4:0]  PORTS_LIM  = 5'(NUM_PORTS);

  logic [31:0] remap_q, cfg1_q, wp1_q, wp2_q;
  logic [7:0]  key_q;
  logic [3:0]  ecc_q;
  logic        pef_q;
  logic [15:0] sel_q [4];
  logic [63:0] sel_flat;

  wire [7:0] widx   = bus_addr[9:2];
  wire       mapped = (bus_addr[1:0] == 2'b00) && (widx <= LAST_WORD);
  wire       wr     = bus_valid && bus_write && mapped;
  wire       rd     = bus_valid && !bus_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap_q <= '0;
      cfg1_q  <= CFG1_RST;
      wp1_q   <= '0;
      wp2_q   <= '0;
      key_q   <= '0;
      ecc_q   <= '0;
      for (int i = 0; i < 4; i++) sel_q[i] <= '0;
    end else if (wr) begin
      case (widx)
        8'd0:  remap_q <= bus_wdata & REMAP_MASK;
        8'd1:  cfg1_q  <= (bus_wdata & CFG1_MASK) | {31'b0, cfg1_q[0] & bus_wdata[0]};
        8'd2:  sel_q[0] <= bus_wdata[15:0];
        8'd3:  sel_q[1] <= bus_wdata[15:0];
        8'd4:  sel_q[2] <= bus_wdata[15:0];
        8'd5:  sel_q[3] <= bus_wdata[15:0];
        8'd7:  ecc_q   <= ecc_q | bus_wdata[3:0];
        8'd8:  wp1_q   <= wp1_q | bus_wdata;
        8'd9:  key_q   <= bus_wdata[7:0];
        8'd10: wp2_q   <= wp2_q | bus_wdata;
        default: ;
      endcase
    end
  end

  wire pef_clr = wr && (widx == 8'd7) && bus_wdata[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pef_q <= 1'b0;
    else if (parity_evt) pef_q <= 1'b1;
    else if (pef_clr)    pef_q <= 1'b0;
  end

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (mapped) begin
      case (widx)
        8'd0:  rd_word = remap_q;
        8'd1:  rd_word = cfg1_q;
        8'd2:  rd_word = {16'b0, sel_q[0]};
        8'd3:  rd_word = {16'b0, sel_q[1]};
        8'd4:  rd_word = {16'b0, sel_q[2]};
        8'd5:  rd_word = {16'b0, sel_q[3]};
        8'd7:  rd_word = {23'b0, pef_q, 4'b0, ecc_q};
        8'd8:  rd_word = wp1_q;
        8'd9:  rd_word = {24'b0, key_q};
        8'd10: rd_word = wp2_q;
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= bus_valid && !mapped;
      if (rd) bus_rdata <= rd_word;
    end
  end

  wire [255:0] pins_ext = 256'(port_pins);
  assign sel_flat = {sel_q[3], sel_q[2], sel_q[1], sel_q[0]};

  for (genvar p = 0; p < 16; p++) begin : g_line
    wire [3:0] fld = sel_flat[p*4 +: 4];
    assign irq_lines[p] = ({1'b0, fld} < PORTS_LIM) ? pins_ext[{fld, 4'(p)}] : 1'b0;
  end
endmodule

module sys_cfg_bank_chk #(
  parameter int NUM_PORTS = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [9:0]  bus_addr,
  input logic [31:0] bus_rdata,
  input logic        bus_err,
  input logic        parity_evt,
  input logic        fw_bit,
  input logic [3:0]  ecc_bits,
  input logic        pef_bit,
  input logic [31:0] wp1_bits,
  input logic [31:0] wp2_bits,
  input logic [63:0] sel_bits,
  input logic [15:0] irq_lines
);
  wire bad = (bus_addr[1:0] != 2'b00) || (bus_addr[9:2] > 8'd10);

  a_r3_fw_never_set: assert property (@(posedge clk) disable iff (!rst_n)
    !fw_bit |=> !fw_bit);
  a_r4_ecc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ecc_bits & $past(ecc_bits)) == $past(ecc_bits)));
  a_r5_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    parity_evt |=> pef_bit);
  a_r6_wp1_accum: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wp1_bits & $past(wp1_bits)) == $past(wp1_bits)));
  a_r6_wp2_accum: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wp2_bits & $past(wp2_bits)) == $past(wp2_bits)));
  a_r7_scsr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == 10'h018) |=> (bus_rdata == 32'h0));
  a_r8_bad_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bad) |=> (bus_err && bus_rdata == 32'h0));
  a_r8_good_noerr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bad) |=> !bus_err);

  for (genvar p = 0; p < 16; p++) begin : g_abs
    a_r11_absent_low: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, sel_bits[p*4 +: 4]} >= 5'(NUM_PORTS)) |-> !irq_lines[p]);
  end
endmodule

bind sys_cfg_bank sys_cfg_bank_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .parity_evt(parity_evt), .fw_bit(cfg1_q[0]), .ecc_bits(ecc_q),
  .pef_bit(pef_q), .wp1_bits(wp1_q), .wp2_bits(wp2_q),
  .sel_bits(sel_flat), .irq_lines(irq_lines)
);

// File: tb/sys_cfg_bank_bench.sv
module sys_cfg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 5;
  localparam int NV = 15;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, parity_evt = 0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err;
  logic [NP*16-1:0] port_pins = '0;
  logic [15:0] irq_lines;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_cfg_bank #(.NUM_PORTS(NP)) u_sys_cfg_bank (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .parity_evt(parity_evt), .port_pins(port_pins),
    .irq_lines(irq_lines)
  );

  // write address, write data, expected readback, requirement number
  localparam logic [9:0]  V_ADDR [NV] = '{10'h000, 10'h024, 10'h008, 10'h004, 10'h004,
    10'h004, 10'h01C, 10'h01C, 10'h01C, 10'h020, 10'h020, 10'h020, 10'h028, 10'h018, 10'h030};
  localparam logic [31:0] V_DATA [NV] = '{32'hFFFFFFFF, 32'h12345678, 32'hABCD1234,
    32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 32'h5, 32'hA, 32'h0, 32'h11, 32'h100, 32'h0,
    32'h80000000, 32'hFFFFFFFF, 32'hFFFFFFFF};
  localparam logic [31:0] V_EXP [NV] = '{32'h107, 32'h78, 32'h1234, 32'hFCFF0101,
    32'h0, 32'hFCFF0100, 32'h5, 32'hF, 32'hF, 32'h11, 32'h111, 32'h111,
    32'h80000000, 32'h0, 32'h0};
  // R2 masks, R3 clear-only bit, R4 sticky, R6 accumulate, R7 ignored, R8 unmapped
  localparam int V_REQ [NV] = '{2, 2, 2, 3, 3, 3, 4, 4, 4, 6, 6, 6, 6, 7, 8};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata; e = bus_err;
  endtask

  function automatic logic [15:0] exp_irq(logic [63:0] sel, logic [NP*16-1:0] pins);
    logic [15:0] r;
    for (int p = 0; p < 16; p++) begin
      int s = int'(sel[p*4 +: 4]);
      r[p] = (s < NP) ? pins[s*16 + p] : 1'b0;
    end
    return r;
  endfunction

  initial begin
    logic [31:0] d;
    logic e;
    logic [63:0] sel;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(10'h004, d, e); check("R1 cfg1 reset", d, 32'h7C000001);
    check("R9 err on good read", {31'b0, e}, 32'h0);
    rd(10'h000, d, e); check("R1 remap reset", d, 32'h0);
    rd(10'h01C, d, e); check("R1 cfg2 reset", d, 32'h0);
    rd(10'h028, d, e); check("R1 wp2 reset", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_DATA[i]);
      rd(V_ADDR[i], d, e);
      check($sformatf("R%0d vector %0d", V_REQ[i], i), d, V_EXP[i]);
    end

    // R9: data for back-to-back reads appears one cycle after each access
    @(negedge clk); bus_valid = 1; bus_addr = 10'h024;
    @(negedge clk); bus_addr = 10'h000;
    check("R9 first read", bus_rdata, 32'h78);
    @(negedge clk); bus_valid = 0;
    check("R9 second read", bus_rdata, 32'h107);

    // R8 unmapped / misaligned
    rd(10'h02C, d, e); check("R8 unmapped read data", d, 32'h0);
    check("R8 unmapped err", {31'b0, e}, 32'h1);
    rd(10'h005, d, e); check("R8 misaligned read err", {31'b0, e}, 32'h1);
    check("R8 misaligned read data", d, 32'h0);
    wr(10'h021, 32'h0000F000);
    rd(10'h020, d, e); check("R8 misaligned write no effect", d, 32'h111);
    rd(10'h3FC, d, e); check("R8 top of window", {31'b0, e}, 32'h1);

    // R5 parity flag
    @(negedge clk); parity_evt = 1; @(negedge clk); parity_evt = 0;
    rd(10'h01C, d, e); check("R5 event sets", d, 32'h10F);
    wr(10'h01C, 32'h0);
    rd(10'h01C, d, e); check("R5 write 0 keeps", d, 32'h10F);
    wr(10'h01C, 32'h100);
    rd(10'h01C, d, e); check("R5 write 1 clears", d, 32'h00F);
    @(negedge clk);
    parity_evt = 1; bus_valid = 1; bus_write = 1; bus_addr = 10'h01C; bus_wdata = 32'h100;
    @(negedge clk);
    parity_evt = 0; bus_valid = 0; bus_write = 0;
    rd(10'h01C, d, e); check("R5 set wins over clear", d, 32'h10F);

    // R10 / R11 interrupt steering: line0->port2, line1->port0, line2->port4, line3->port7
    wr(10'h008, 32'h00007402);
    wr(10'h00C, 32'h00003210);
    wr(10'h010, 32'h0000F954);
    wr(10'h014, 32'h00000123);
    sel = {16'h0123, 16'hF954, 16'h3210, 16'h7402};
    port_pins = '1;
    #1; check("R11 absent port low", {16'b0, irq_lines}, {16'b0, exp_irq(sel, port_pins)});
    check("R11 line3 low", {31'b0, irq_lines[3]}, 32'h0);
    port_pins = {16'hF0F0, 16'h0FF0, 16'hAAAA, 16'h5555, 16'h3C3C};
    #1; check("R10 pattern A", {16'b0, irq_lines}, {16'b0, exp_irq(sel, port_pins)});
    port_pins = {16'h1234, 16'hFEDC, 16'h0001, 16'h8000, 16'hC3A5};
    #1; check("R10 pattern B", {16'b0, irq_lines}, {16'b0, exp_irq(sel, port_pins)});
    port_pins = '0; port_pins[2*16 + 0] = 1'b1;
    #1; check("R10 line0 from port2 pin0", {16'b0, irq_lines}, 32'h0001);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule